// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between the request flags of a small processor's peripherals and the processor core. It arbitrates among sixteen fixed-priority slots. It hands the core the number of the winning slot and the 16-bit address of the vector word the core must fetch to enter that slot's handler. Each of the fifteen lower slots takes a group of request flags, and each flag has its own enable bit. The top slot is the reset slot, which no enable can block.

Slot 14 is semi-nonmaskable. Its per-flag enables still gate it, but the global interrupt enable does not. Slots 13 down to 0 need both their flag's enable bit and the global enable. The arbitration result is registered and held until the core acknowledges it. The block then returns a one-cycle strobe to the granted slot so that its peripheral can clear the flag. Taking a vector clears the global enable. Taking the reset vector also clears every per-flag enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When several slots are eligible in the same cycle, the highest-numbered one is granted.
- R2: While a request is presented, `irq_vec_o` equals 16'hFFE0 + 2 × `irq_slot_o`, so slot 15 maps to 16'hFFFE and slot 0 to 16'hFFE0.
- R3: On the first clock edge after reset is released, the block requests slot 15 with vector 16'hFFFE. This pending boot request lasts until slot 15 is acknowledged.
- R4: Any bit of `rst_src_i` makes slot 15 eligible whatever the enables and the global enable hold. If a lower slot is being held when this happens, the held grant is replaced by slot 15 on the next edge.
- R5: Slot 14 is eligible when one of its flags and that flag's enable bit are both set, even with the global enable clear. It is not eligible while the matching enable bits are clear.
- R6: Slots 0 to 13 are eligible only when the global enable is set as well as a flag and its enable bit.
- R7: Flag k of slot s sits at `flag_i[s*SLOT_FLAGS+k]` and its enable at bit s*SLOT_FLAGS+k of the enable register. A slot is eligible when any such pair is set together. A flag whose own enable is clear does not count, even if other enables of the slot are set.
- R8: Once `irq_req_o` is high, it and `irq_slot_o` stay unchanged until an edge with `irq_ack_i` high. The only exception is the slot 15 takeover of R4.
- R9: An edge with both `irq_req_o` and `irq_ack_i` high drops `irq_req_o`. After that edge, `slot_ack_o` shows for one cycle the single bit of the granted slot. At all other times `slot_ack_o` is zero.
- R10: Acknowledging any slot clears the global enable, and this takes precedence over a global-enable write in the same cycle. Acknowledging slot 15 also clears all enable bits.
- R11: Asserting `rst_n` low clears the global enable, all enable bits, the request and the acknowledge strobes.
- R12: An edge with `en_we_i` high loads `en_wdata_i` into the enable register. An edge with `gie_we_i` high loads `gie_wdata_i` into the global enable, which `gie_o` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| flag_i | input | 120 | Request flags of slots 0 to 14, SLOT_FLAGS per slot |
| rst_src_i | input | 3 | Reset-slot sources (pin, watchdog expiry, bad key) |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 120 | New enable register value |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | New global enable value |
| gie_o | output | 1 | Current global enable |
| irq_req_o | output | 1 | Request to the core |
| irq_slot_o | output | 4 | Granted slot number |
| irq_vec_o | output | 16 | Vector word address of the granted slot |
| irq_ack_i | input | 1 | Core acknowledge of the presented vector |
| slot_ack_o | output | 16 | One-cycle acknowledge strobe per slot |

## Verification
The bench builds the block with four flags per slot and two reset sources, keeping sixteen slots and the default vector base. With these values every slot can be driven by name, and one slot can hold a mix of enabled and disabled flags, which exercises the partial-enable case of R7. Two reset sources are enough to show that any one of them takes slot 15. The behavioural model walks through the boot vector, the global-enable and semi-nonmaskable gating, arbitration among three slots, hold-until-acknowledge, reset takeover of a held grant, and a global-enable write that collides with an acknowledge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  // Gating class of a flag slot.
  typedef enum logic [0:0] {
    GATE_MASKABLE = 1'b0,
    GATE_SEMI_NMI = 1'b1
  } gate_class_e;

  // Class of slot number s in a controller with n_levels slots.
  function automatic gate_class_e class_of_slot(input int unsigned s,
                                                input int unsigned n_levels);
    return (s == n_levels - 2) ? GATE_SEMI_NMI : GATE_MASKABLE;
  endfunction

endpackage

// File: rtl/irq_slot_gate.sv
module irq_slot_gate
  import irq_vec_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter gate_class_e CLASS = GATE_MASKABLE
) (
  input  logic [WIDTH-1:0] flag_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic             gie_i,
  output logic             req_o
);

  logic member_hit;
  logic gate_open;

  // Any flag whose own enable is set.
  assign member_hit = |(flag_i & en_i);

  // The semi-nonmaskable class bypasses the global enable.
  assign gate_open = gie_i | (CLASS == GATE_SEMI_NMI);

  assign req_o = member_hit & gate_open;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // Scan upward so that the highest set bit is the last assignment.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_grant_ctrl.sv
module irq_grant_ctrl #(
  parameter int unsigned N         = 16,
  parameter int unsigned IDX_W     = $clog2(N),
  parameter int unsigned TOP_LEVEL = N - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             done_o,
  output logic [N-1:0]     strobe_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TOP_LEVEL);

  logic             req_q,    req_d;
  logic [IDX_W-1:0] slot_q,   slot_d;
  logic             slot_le;
  logic [N-1:0]     strobe_q, strobe_d;

  assign done_o = req_q & ack_i;

  // Next state: take a new winner when idle, hold until acknowledged,
  // and let only the top slot replace a grant that is being held.
  always_comb begin
    req_d    = req_q;
    slot_d   = slot_q;
    slot_le  = 1'b0;
    strobe_d = '0;
    if (req_q) begin
      if (ack_i) begin
        req_d = 1'b0;
        for (int i = 0; i < N; i++) begin
          strobe_d[i] = (slot_q == IDX_W'(i));
        end
      end else if (any_i && (win_i == TOP_IDX) && (slot_q != TOP_IDX)) begin
        slot_d  = TOP_IDX;
        slot_le = 1'b1;
      end
    end else if (any_i) begin
      req_d   = 1'b1;
      slot_d  = win_i;
      slot_le = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      slot_q   <= '0;
      strobe_q <= '0;
    end else begin
      req_q    <= req_d;
      strobe_q <= strobe_d;
      if (slot_le) begin
        slot_q <= slot_d;
      end
    end
  end

  assign req_o    = req_q;
  assign slot_o   = slot_q;
  assign strobe_o = strobe_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned      NUM_LEVELS = 16,
  parameter int unsigned      SLOT_FLAGS = 8,
  parameter int unsigned      RST_SRCS   = 3,
  parameter int unsigned      VEC_W      = 16,
  parameter logic [VEC_W-1:0] VEC_BASE   = 'hFFE0,
  localparam int unsigned     IDX_W      = $clog2(NUM_LEVELS),
  localparam int unsigned     FLAG_W     = (NUM_LEVELS - 1) * SLOT_FLAGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_i,
  input  logic [RST_SRCS-1:0] rst_src_i,
  input  logic              en_we_i,
  input  logic [FLAG_W-1:0] en_wdata_i,
  input  logic              gie_we_i,
  input  logic              gie_wdata_i,
  output logic              gie_o,
  output logic              irq_req_o,
  output logic [IDX_W-1:0]  irq_slot_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i,
  output logic [NUM_LEVELS-1:0] slot_ack_o
);

  localparam int unsigned      MASK_LEVELS = NUM_LEVELS - 1;
  localparam int unsigned      TOP_LEVEL   = NUM_LEVELS - 1;
  localparam logic [IDX_W-1:0] TOP_IDX     = IDX_W'(TOP_LEVEL);

  // Enable state and the boot request.
  logic              gie_q,  gie_d;
  logic [FLAG_W-1:0] en_q,   en_d;
  logic              boot_q, boot_d;

  // Arbitration.
  logic [NUM_LEVELS-1:0] slot_req;
  logic                  pick_any;
  logic [IDX_W-1:0]      pick_idx;
  logic                  grant_done;
  logic                  top_done;

  // One gate per flag slot; the class comes from the slot number.
  for (genvar s = 0; s < MASK_LEVELS; s++) begin : g_slot
    irq_slot_gate #(
      .WIDTH (SLOT_FLAGS),
      .CLASS (class_of_slot(s, NUM_LEVELS))
    ) u_gate (
      .flag_i (flag_i[s*SLOT_FLAGS +: SLOT_FLAGS]),
      .en_i   (en_q[s*SLOT_FLAGS +: SLOT_FLAGS]),
      .gie_i  (gie_q),
      .req_o  (slot_req[s])
    );
  end

  // The reset slot ignores every enable.
  assign slot_req[TOP_LEVEL] = boot_q | (|rst_src_i);

  irq_prio_pick #(
    .N     (NUM_LEVELS),
    .IDX_W (IDX_W)
  ) u_pick (
    .req_i (slot_req),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  irq_grant_ctrl #(
    .N         (NUM_LEVELS),
    .IDX_W     (IDX_W),
    .TOP_LEVEL (TOP_LEVEL)
  ) u_grant (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_i    (pick_any),
    .win_i    (pick_idx),
    .ack_i    (irq_ack_i),
    .req_o    (irq_req_o),
    .slot_o   (irq_slot_o),
    .done_o   (grant_done),
    .strobe_o (slot_ack_o)
  );

  assign top_done = grant_done & (irq_slot_o == TOP_IDX);

  // Next state of the enables: software writes first, then an
  // acknowledge overrides them.
  always_comb begin
    gie_d  = gie_we_i ? gie_wdata_i : gie_q;
    en_d   = en_we_i  ? en_wdata_i  : en_q;
    boot_d = boot_q;
    if (grant_done) begin
      gie_d = 1'b0;
    end
    if (top_done) begin
      en_d   = '0;
      boot_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      boot_q <= 1'b1;
    end else begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      boot_q <= boot_d;
    end
  end

  assign gie_o     = gie_q;
  assign irq_vec_o = VEC_BASE + (VEC_W'(irq_slot_o) << 1);

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned      NUM_LEVELS = 16,
  parameter int unsigned      RST_SRCS   = 3,
  parameter int unsigned      VEC_W      = 16,
  parameter logic [VEC_W-1:0] VEC_BASE   = 'hFFE0,
  localparam int unsigned     IDX_W      = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [RST_SRCS-1:0]   rst_src_i,
  input logic                  irq_req_o,
  input logic [IDX_W-1:0]      irq_slot_o,
  input logic [VEC_W-1:0]      irq_vec_o,
  input logic                  irq_ack_i,
  input logic [NUM_LEVELS-1:0] slot_ack_o,
  input logic                  gie_q
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_LEVELS - 1);

  assert_vec_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o == VEC_BASE + (VEC_W'(irq_slot_o) << 1)));

  assert_reset_takes_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_src_i != '0) && !(irq_req_o && irq_ack_i)) |=> (irq_req_o && (irq_slot_o == TOP_IDX)));

  assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !irq_ack_i && (rst_src_i == '0)) |=> (irq_req_o && $stable(irq_slot_o)));

  assert_ack_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_ack_i) |=> (!irq_req_o && (slot_ack_o == (NUM_LEVELS'(1) << $past(irq_slot_o)))));

  assert_no_stray_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req_o && irq_ack_i) |=> (slot_ack_o == '0));

  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_ack_o));

  assert_gie_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_ack_i) |=> !gie_q);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NUM_LEVELS (NUM_LEVELS),
  .RST_SRCS   (RST_SRCS),
  .VEC_W      (VEC_W),
  .VEC_BASE   (VEC_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_src_i  (rst_src_i),
  .irq_req_o  (irq_req_o),
  .irq_slot_o (irq_slot_o),
  .irq_vec_o  (irq_vec_o),
  .irq_ack_i  (irq_ack_i),
  .slot_ack_o (slot_ack_o),
  .gie_q      (gie_q)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEVELS     = 16;
  localparam int SF         = 4;
  localparam int NRST       = 2;
  localparam int FW         = (LEVELS - 1) * SF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [FW-1:0]   flag;
  logic [NRST-1:0] rst_src;
  logic            en_we;
  logic [FW-1:0]   en_wdata;
  logic            gie_we;
  logic            gie_wdata;
  logic            gie_o;
  logic            irq_req;
  logic [3:0]      irq_slot;
  logic [15:0]     irq_vec;
  logic            irq_ack;
  logic [LEVELS-1:0] slot_ack;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [FW-1:0] en_shadow;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl #(
    .NUM_LEVELS (LEVELS),
    .SLOT_FLAGS (SF),
    .RST_SRCS   (NRST)
  ) u_irq_vector_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_i      (flag),
    .rst_src_i   (rst_src),
    .en_we_i     (en_we),
    .en_wdata_i  (en_wdata),
    .gie_we_i    (gie_we),
    .gie_wdata_i (gie_wdata),
    .gie_o       (gie_o),
    .irq_req_o   (irq_req),
    .irq_slot_o  (irq_slot),
    .irq_vec_o   (irq_vec),
    .irq_ack_i   (irq_ack),
    .slot_ack_o  (slot_ack)
  );

  // ---------------- behavioural reference model ----------------
  logic              m_req;
  int                m_slot;
  logic              m_gie;
  logic [FW-1:0]     m_en;
  logic              m_boot;
  logic [LEVELS-1:0] m_ack;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 1'b0; m_slot = 0; m_gie = 1'b0; m_en = '0; m_boot = 1'b1; m_ack = '0;
    end else begin
      int win;
      win = -1;
      for (int s = 0; s < LEVELS - 1; s++) begin
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < SF; k++) if (flag[s*SF+k] && m_en[s*SF+k]) hit = 1'b1;
        if (hit && (m_gie || s == LEVELS - 2)) win = s;
      end
      if (m_boot || rst_src != '0) win = LEVELS - 1;
      if (gie_we) m_gie = gie_wdata;
      if (en_we)  m_en  = en_wdata;
      m_ack = '0;
      if (m_req && irq_ack) begin
        m_ack[m_slot] = 1'b1;
        m_req = 1'b0;
        m_gie = 1'b0;
        if (m_slot == LEVELS - 1) begin m_en = '0; m_boot = 1'b0; end
      end else if (m_req) begin
        if (win == LEVELS - 1) m_slot = win;
      end else if (win >= 0) begin
        m_req = 1'b1; m_slot = win;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle compare against the model.
  always @(negedge clk) begin
    chk("R8 req", 32'(irq_req), 32'(m_req));
    if (m_req) begin
      chk("R1 slot", 32'(irq_slot), 32'(m_slot));
      chk("R2 vector", 32'(irq_vec), 32'h0000FFE0 + 32'(2 * m_slot));
    end
    chk("R9 strobe", 32'(slot_ack), 32'(m_ack));
    chk("R12 gie", 32'(gie_o), 32'(m_gie));
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick;
    @(negedge clk);
    cycles++;
  endtask

  task automatic wr_en(input logic [FW-1:0] v);
    en_shadow = v; en_we = 1'b1; en_wdata = v; tick; en_we = 1'b0;
  endtask

  task automatic wr_gie(input logic v);
    gie_we = 1'b1; gie_wdata = v; tick; gie_we = 1'b0;
  endtask

  task automatic do_ack;
    irq_ack = 1'b1; tick; irq_ack = 1'b0;
  endtask

  function automatic int fb(input int s, input int k);
    return s * SF + k;
  endfunction

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Watchdog.
  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [FW-1:0] e;
    rst_n = 1'b0; flag = '0; rst_src = '0; en_we = 1'b0; en_wdata = '0;
    gie_we = 1'b0; gie_wdata = 1'b0; irq_ack = 1'b0; en_shadow = '0;
    tick; tick; tick;
    chk("R11 reset req", 32'(irq_req), 0);
    chk("R11 reset gie", 32'(gie_o), 0);
    chk("R11 reset strobe", 32'(slot_ack), 0);
    #1 rst_n = 1'b1;

    // R3: boot vector first.
    tick;
    chk("R3 boot req", 32'(irq_req), 1);
    chk("R3 boot vector", 32'(irq_vec), 32'hFFFE);
    do_ack;
    chk("R9 boot strobe", 32'(slot_ack), 32'h8000);
    tick;
    chk("R9 strobe one cycle", 32'(slot_ack), 0);
    chk("R3 boot cleared", 32'(irq_req), 0);

    // R7/R6: flag without its enable.
    flag[fb(5,2)] = 1'b1;
    wr_gie(1'b1);
    chk("R12 gie set", 32'(gie_o), 1);
    tick;
    chk("R7 no enable no req", 32'(irq_req), 0);
    e = '0; e[fb(5,2)] = 1'b1;
    wr_en(e);
    tick;
    chk("R7 slot5 req", 32'(irq_req), 1);
    chk("R2 slot5 vector", 32'(irq_vec), 32'hFFEA);
    do_ack;
    chk("R9 slot5 strobe", 32'(slot_ack), 32'h0020);
    chk("R10 gie cleared", 32'(gie_o), 0);
    tick; tick;
    chk("R6 gie blocks slot5", 32'(irq_req), 0);

    // R5: semi-nonmaskable slot.
    flag[fb(14,0)] = 1'b1;
    tick; tick;
    chk("R5 own enable blocks", 32'(irq_req), 0);
    e = en_shadow; e[fb(14,0)] = 1'b1;
    wr_en(e);
    tick;
    chk("R5 slot14 without gie", 32'(irq_slot), 14);
    chk("R5 slot14 vector", 32'(irq_vec), 32'hFFFC);
    do_ack; flag[fb(14,0)] = 1'b0;
    tick;
    chk("R6 still blocked", 32'(irq_req), 0);

    // R7 partial enable: slot 2 flag 1 set but only enable 3 set.
    flag[fb(2,1)] = 1'b1;
    e = en_shadow; e[fb(2,3)] = 1'b1;
    wr_en(e);
    wr_gie(1'b1);
    tick;
    chk("R7 slot2 wrong member", 32'(irq_slot), 5);
    do_ack; flag[fb(5,2)] = 1'b0;
    flag[fb(2,1)] = 1'b0;

    // R1: three slots at once.
    flag[fb(3,0)] = 1'b1; flag[fb(9,1)] = 1'b1; flag[fb(12,3)] = 1'b1; flag[fb(5,2)] = 1'b1;
    e = en_shadow; e[fb(3,0)] = 1'b1; e[fb(9,1)] = 1'b1; e[fb(12,3)] = 1'b1;
    wr_en(e);
    wr_gie(1'b1);
    tick;
    chk("R1 slot12 wins", 32'(irq_slot), 12);
    chk("R2 slot12 vector", 32'(irq_vec), 32'hFFF8);
    do_ack; flag[fb(12,3)] = 1'b0;
    tick; tick;
    chk("R10 no maskable after ack", 32'(irq_req), 0);
    wr_gie(1'b1);
    tick;
    chk("R1 slot9 next", 32'(irq_slot), 9);
    do_ack; flag[fb(9,1)] = 1'b0;

    // R10: gie write collides with acknowledge.
    wr_gie(1'b1);
    tick;
    chk("R1 slot5 next", 32'(irq_slot), 5);
    gie_we = 1'b1; gie_wdata = 1'b1; irq_ack = 1'b1;
    tick;
    gie_we = 1'b0; irq_ack = 1'b0; flag[fb(5,2)] = 1'b0;
    chk("R10 ack beats gie write", 32'(gie_o), 0);

    // R8: held grant ignores a higher maskable slot.
    wr_gie(1'b1);
    tick;
    chk("R12 slot3 after gie write", 32'(irq_slot), 3);
    flag[fb(13,1)] = 1'b1;
    e = en_shadow; e[fb(13,1)] = 1'b1;
    wr_en(e);
    tick; tick;
    chk("R8 slot3 held", 32'(irq_slot), 3);
    do_ack; flag[fb(3,0)] = 1'b0;
    chk("R9 slot3 strobe", 32'(slot_ack), 32'h0008);
    wr_gie(1'b1);
    tick;
    chk("R1 slot13", 32'(irq_slot), 13);

    // R4: reset source takes over a held grant.
    rst_src[1] = 1'b1;
    tick;
    chk("R4 takeover slot", 32'(irq_slot), 15);
    chk("R4 takeover vector", 32'(irq_vec), 32'hFFFE);
    do_ack; rst_src = '0;
    chk("R9 slot15 strobe", 32'(slot_ack), 32'h8000);
    wr_gie(1'b1);
    tick; tick;
    chk("R10 enables cleared", 32'(irq_req), 0);

    // R4: reset source with everything disabled.
    wr_gie(1'b0);
    rst_src[0] = 1'b1;
    tick;
    chk("R4 ignores enables", 32'(irq_slot), 15);
    do_ack; rst_src = '0;
    flag = '0;

    // R11: mid-run reset.
    wr_gie(1'b1);
    @(negedge clk); #1 rst_n = 1'b0;
    tick;
    chk("R11 gie cleared", 32'(gie_o), 0);
    #1 rst_n = 1'b1;
    tick;
    chk("R3 boot after re-reset", 32'(irq_vec), 32'hFFFE);
    do_ack;
    tick;
    finish_run();
  end

endmodule